// File: doc/BRIEF.md
# Fax Modem Transmit Training Sequencer

This block paces a half-duplex fax modem transmitter through its start-up and shut-down line sequences, one decision per symbol strobe. When the request-to-send input is seen high at a strobe while idle, it walks through the training segments. Each segment labels its symbols as one of four training points (A, B, C, D), or marks them as data-mode symbols or silence. At the end of training it raises ready-for-sending and routes user data to the scrambler. When request-to-send falls, it runs a fixed turn-off tail.

The sequencer does not own the scrambler or the encoders. It tells the attached scrambler when to hold its seed, when to step, and which dibit to scramble. It takes the scrambled dibit back for the current symbol. It also hands the data-mode differential encoder its starting symbol and tells the encoders when to initialise. A level input chooses a full start-up (long train, with the bridge segment) or a short resynchronisation. Point coordinates, echo-protection tones and receiver functions live elsewhere.

Top module: `train_seq`

## Requirements
- R1: After reset, sym_kind is silent (00), cts is low and scr_run is low.
- R2: A long train, started by the strobe that finds rts high in idle (that strobe itself emits silence), emits these segments in order: 256 training symbols alternating A, B starting with A; 2976 equalizer symbols; 64 bridge symbols; 48 data-mode symbols (kind 10). Training symbols carry kind 01 and label A=0, B=1, C=2, D=3.
- R3: A resync (long_train low at the starting strobe) emits 256 alternation symbols, then 2938 equalizer symbols, then the 48 data-mode symbols, with no bridge segment.
- R4: Each equalizer symbol's label is taken straight from the scrambled dibit scr_dout given with its strobe: 00 gives C, 01 gives D, 11 gives A, 10 gives B.
- R5: During bridge symbol j (counted from 0), scr_din holds bit 2*(j mod 8) of BRIDGE_PAT in scr_din[1] and bit 2*(j mod 8)+1 in scr_din[0].
- R6: Each bridge label is the previous emitted label, rotated by the scrambled dibit: 00 advances one step (A to B, B to C, C to D, D to A), 01 keeps it, 10 advances two steps, 11 steps back one. The first bridge symbol rotates from the last equalizer label.
- R7: Between the last pre-data strobe and the first data-mode training strobe, enc_init is high and dif_seed holds the first bridge label (long train) or the last equalizer label (resync).
- R8: The strobe that ends the 48th data-mode training symbol, with rts high, sets cts high. cts and scr_use_data are then high together until turn-off.
- R9: The first strobe in data mode that finds rts low drops cts. The block then emits 32 more data-mode symbols, then 48 silent symbols, then returns to idle.
- R10: rts going high during the 80-symbol turn-off tail has no effect until the tail ends. The silent symbols still all come out, and the next train starts only at an idle strobe after them.
- R11: If rts falls during training, training still completes. cts never rises, and the turn-off tail follows the last data-mode training symbol directly.
- R12: scr_load is high only during alternation. scr_run is high from the equalizer segment through the 32 turn-off data-mode symbols. scr_din is 11 in all scrambler-running segments except bridge and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_stb | input | 1 | One-cycle pulse per symbol interval |
| rts | input | 1 | Request to send |
| long_train | input | 1 | 1 selects long train, 0 resync, sampled at start |
| scr_dout | input | 2 | Scrambled dibit for the current symbol, first bit in [1] |
| sym_kind | output | 2 | 00 silent, 01 training label, 10 data-mode symbol |
| sym_label | output | 2 | Training label A=0, B=1, C=2, D=3 |
| cts | output | 1 | Ready for sending |
| scr_load | output | 1 | Scrambler holds its training seed |
| scr_run | output | 1 | Scrambler steps on each strobe |
| scr_din | output | 2 | Dibit fed to scrambler input when user data is not routed |
| scr_use_data | output | 1 | Route user data to scrambler input |
| dif_seed | output | 2 | Starting symbol for the data differential encoder |
| enc_init | output | 1 | Encoders initialise at the next strobe |

## Verification
Symbol results (sym_kind, sym_label, cts, dif_seed) are registered at the clock edge that samples the strobe, so they are due one edge after the strobe. The bench reads them at the falling edge right after that. The scrambler controls (scr_load, scr_run, scr_din, scr_use_data, enc_init) depend only on the current segment and position, so they are read at the falling edge before the strobe that consumes them. The expected labels come from a model that replays the dibits the bench itself supplied on scr_dout.

// File: rtl/train_seq_pkg.sv
package train_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ALT, ST_EQ, ST_BRIDGE, ST_ONES, ST_DATA, ST_OFF_ONES, ST_OFF_SIL
  } seq_state_t;

  localparam logic [1:0] KIND_SIL   = 2'b00;
  localparam logic [1:0] KIND_TRAIN = 2'b01;
  localparam logic [1:0] KIND_DATA  = 2'b10;

  localparam logic [1:0] LBL_A = 2'd0;
  localparam logic [1:0] LBL_B = 2'd1;
  localparam logic [1:0] LBL_C = 2'd2;
  localparam logic [1:0] LBL_D = 2'd3;

  // direct dibit to point map for the equalizer segment
  function automatic logic [1:0] eq_label(input logic [1:0] d);
    case (d)
      2'b00:   eq_label = LBL_C;
      2'b01:   eq_label = LBL_D;
      2'b11:   eq_label = LBL_A;
      default: eq_label = LBL_B;
    endcase
  endfunction

  // quarter-turn steps for the differential bridge map (labels are cyclic)
  function automatic logic [1:0] rot_step(input logic [1:0] d);
    case (d)
      2'b00:   rot_step = 2'd1;
      2'b01:   rot_step = 2'd0;
      2'b10:   rot_step = 2'd2;
      default: rot_step = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/train_seq_ctrl.sv
module train_seq_ctrl
  import train_seq_pkg::*;
#(
  parameter int CNT_W        = 12,
  parameter int ALT_LEN      = 256,
  parameter int EQ_LONG_LEN  = 2976,
  parameter int EQ_SHORT_LEN = 2938,
  parameter int BRIDGE_LEN   = 64,
  parameter int ONES_LEN     = 48,
  parameter int OFF_ONES_LEN = 32,
  parameter int OFF_SIL_LEN  = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_stb,
  input  logic             rts,
  input  logic             long_sel,
  output seq_state_t       state,
  output logic [CNT_W-1:0] cnt,
  output logic             seg_end,
  output logic             long_q,
  output logic             cts
);

  logic [CNT_W-1:0] seg_len;

  always_comb begin
    case (state)
      ST_ALT:      seg_len = CNT_W'(ALT_LEN);
      ST_EQ:       seg_len = long_q ? CNT_W'(EQ_LONG_LEN) : CNT_W'(EQ_SHORT_LEN);
      ST_BRIDGE:   seg_len = CNT_W'(BRIDGE_LEN);
      ST_ONES:     seg_len = CNT_W'(ONES_LEN);
      ST_OFF_ONES: seg_len = CNT_W'(OFF_ONES_LEN);
      ST_OFF_SIL:  seg_len = CNT_W'(OFF_SIL_LEN);
      default:     seg_len = CNT_W'(1);
    endcase
  end

  assign seg_end = (cnt == seg_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      long_q <= 1'b0;
      cts    <= 1'b0;
    end else if (sym_stb) begin
      cnt <= seg_end ? '0 : cnt + CNT_W'(1);
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (rts) begin
            state  <= ST_ALT;
            long_q <= long_sel;
          end
        end
        ST_ALT:    if (seg_end) state <= ST_EQ;
        ST_EQ:     if (seg_end) state <= long_q ? ST_BRIDGE : ST_ONES;
        ST_BRIDGE: if (seg_end) state <= ST_ONES;
        ST_ONES: begin
          if (seg_end) begin
            if (rts) begin
              state <= ST_DATA;
              cts   <= 1'b1;
            end else begin
              state <= ST_OFF_ONES;
            end
          end
        end
        ST_DATA: begin
          cnt <= '0;
          if (!rts) begin
            state <= ST_OFF_ONES;
            cts   <= 1'b0;
          end
        end
        ST_OFF_ONES: if (seg_end) state <= ST_OFF_SIL;
        ST_OFF_SIL:  if (seg_end) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/train_seq_labeler.sv
module train_seq_labeler
  import train_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb,
  input  seq_state_t state,
  input  logic       cnt_lsb,
  input  logic       cnt_zero,
  input  logic       seg_end,
  input  logic       long_q,
  input  logic [1:0] scr_dout,
  output logic [1:0] sym_kind,
  output logic [1:0] sym_label,
  output logic [1:0] dif_seed
);

  logic [1:0] next_label;
  logic [1:0] next_kind;

  always_comb begin
    next_label = sym_label;
    next_kind  = KIND_SIL;
    case (state)
      ST_ALT: begin
        next_kind  = KIND_TRAIN;
        next_label = cnt_lsb ? LBL_B : LBL_A;
      end
      ST_EQ: begin
        next_kind  = KIND_TRAIN;
        next_label = eq_label(scr_dout);
      end
      ST_BRIDGE: begin
        next_kind  = KIND_TRAIN;
        next_label = sym_label + rot_step(scr_dout);
      end
      ST_ONES, ST_DATA, ST_OFF_ONES: next_kind = KIND_DATA;
      default: next_kind = KIND_SIL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_kind  <= KIND_SIL;
      sym_label <= LBL_A;
      dif_seed  <= LBL_A;
    end else if (sym_stb) begin
      sym_kind  <= next_kind;
      sym_label <= next_label;
      if ((state == ST_BRIDGE && cnt_zero) || (state == ST_EQ && seg_end && !long_q))
        dif_seed <= next_label;
    end
  end

endmodule

// File: rtl/train_seq.sv
module train_seq
  import train_seq_pkg::*;
#(
  parameter int          CNT_W        = 12,
  parameter int          ALT_LEN      = 256,
  parameter int          EQ_LONG_LEN  = 2976,
  parameter int          EQ_SHORT_LEN = 2938,
  parameter int          BRIDGE_LEN   = 64,
  parameter int          ONES_LEN     = 48,
  parameter int          OFF_ONES_LEN = 32,
  parameter int          OFF_SIL_LEN  = 48,
  parameter logic [15:0] BRIDGE_PAT   = 16'h8888
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sym_stb,
  input  logic       rts,
  input  logic       long_train,
  input  logic [1:0] scr_dout,
  output logic [1:0] sym_kind,
  output logic [1:0] sym_label,
  output logic       cts,
  output logic       scr_load,
  output logic       scr_run,
  output logic [1:0] scr_din,
  output logic       scr_use_data,
  output logic [1:0] dif_seed,
  output logic       enc_init
);

  localparam int PAT_DIBITS = 8;
  localparam int IDX_W      = $clog2(PAT_DIBITS);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             seg_end;
  logic             long_q;
  logic [IDX_W-1:0] pat_idx;
  logic             cnt_zero;

  train_seq_ctrl #(
    .CNT_W(CNT_W), .ALT_LEN(ALT_LEN), .EQ_LONG_LEN(EQ_LONG_LEN),
    .EQ_SHORT_LEN(EQ_SHORT_LEN), .BRIDGE_LEN(BRIDGE_LEN), .ONES_LEN(ONES_LEN),
    .OFF_ONES_LEN(OFF_ONES_LEN), .OFF_SIL_LEN(OFF_SIL_LEN)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .rts(rts), .long_sel(long_train),
    .state(state), .cnt(cnt), .seg_end(seg_end), .long_q(long_q), .cts(cts)
  );

  assign cnt_zero = (cnt == '0);
  assign pat_idx  = cnt[IDX_W-1:0];

  train_seq_labeler u_lab (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .state(state),
    .cnt_lsb(cnt[0]), .cnt_zero(cnt_zero), .seg_end(seg_end), .long_q(long_q),
    .scr_dout(scr_dout), .sym_kind(sym_kind), .sym_label(sym_label),
    .dif_seed(dif_seed)
  );

  // scrambler and encoder steering follows the registered segment state
  always_comb begin
    scr_load     = (state == ST_ALT);
    scr_use_data = (state == ST_DATA);
    enc_init     = (state == ST_ONES) && cnt_zero;
    scr_run      = (state == ST_EQ) || (state == ST_BRIDGE) || (state == ST_ONES) ||
                   (state == ST_DATA) || (state == ST_OFF_ONES);
    if (state == ST_BRIDGE)
      scr_din = {BRIDGE_PAT[{pat_idx, 1'b0}], BRIDGE_PAT[{pat_idx, 1'b1}]};
    else
      scr_din = 2'b11;
  end

endmodule

// File: rtl/train_seq_chk.sv
module train_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       sym_stb,
  input logic       rts,
  input logic [1:0] sym_kind,
  input logic       cts,
  input logic       scr_run,
  input logic       scr_use_data
);

  assert_cts_only_data_R8: assert property (@(posedge clk) disable iff (rst)
    cts |-> sym_kind == 2'b10);

  assert_cts_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (sym_stb && cts && !rts) |=> !cts);

  assert_cts_rise_on_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cts) |-> $past(sym_stb));

  assert_data_route_R8: assert property (@(posedge clk) disable iff (rst)
    scr_use_data |-> cts);

  assert_silent_scr_off_R12: assert property (@(posedge clk) disable iff (rst)
    (sym_kind == 2'b00) |-> !scr_run);

  assert_hold_between_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    !sym_stb |=> ($stable(sym_kind) && $stable(cts)));

endmodule

bind train_seq train_seq_chk u_chk (
  .clk(clk), .rst(rst), .sym_stb(sym_stb), .rts(rts), .sym_kind(sym_kind),
  .cts(cts), .scr_run(scr_run), .scr_use_data(scr_use_data)
);

// File: tb/train_seq_bench.sv
module train_seq_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_stb = 1'b0;
  logic       rts = 1'b0;
  logic       long_train = 1'b1;
  logic [1:0] scr_dout = 2'b00;
  logic [1:0] sym_kind, sym_label, scr_din, dif_seed;
  logic       cts, scr_load, scr_run, scr_use_data, enc_init;

  int checks = 0;
  int errors = 0;
  logic [15:0] lf = 16'hACE1;

  localparam logic [15:0] PAT = 16'h8888;
  // per-dibit expectations: equalizer label and bridge rotation step (A=0..D=3)
  localparam logic [1:0] EQ_TAB  [4] = '{2'd2, 2'd3, 2'd1, 2'd0};
  localparam logic [1:0] ROT_TAB [4] = '{2'd1, 2'd0, 2'd2, 2'd3};
  // segment table: length of alternation, equalizer(long), bridge, data-mode training
  localparam int SEG_LEN [4] = '{256, 2976, 64, 48};
  localparam int EQ_SHORT = 2938;

  always #10 clk = ~clk;

  train_seq u_train_seq (
    .clk(clk), .rst(rst), .sym_stb(sym_stb), .rts(rts), .long_train(long_train),
    .scr_dout(scr_dout), .sym_kind(sym_kind), .sym_label(sym_label), .cts(cts),
    .scr_load(scr_load), .scr_run(scr_run), .scr_din(scr_din),
    .scr_use_data(scr_use_data), .dif_seed(dif_seed), .enc_init(enc_init)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one symbol: strobe with dibit d, results sampled at the next falling edge
  task automatic step(input logic [1:0] d);
    @(negedge clk);
    sym_stb  = 1'b1;
    scr_dout = d;
    @(negedge clk);
    sym_stb = 1'b0;
  endtask

  function automatic logic [1:0] next_dibit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[1:0];
  endfunction

  task automatic run_train(input bit is_long, input int drop_at);
    logic [1:0] prev = 2'd0;
    logic [1:0] seed = 2'd0;
    logic [1:0] d;
    long_train = is_long;
    step(2'b00);
    chk(sym_kind == 2'b00, "R2 start strobe silent", sym_kind, 0);
    for (int s = 0; s < 4; s++) begin
      int len = SEG_LEN[s];
      if (s == 1 && !is_long) len = EQ_SHORT;
      if (s == 2 && !is_long) continue;
      for (int i = 0; i < len; i++) begin
        d = next_dibit();
        if (i == 0) begin
          chk(scr_load == (s == 0), "R12 scr_load", scr_load, s == 0);
          chk(scr_run == (s != 0), "R12 scr_run", scr_run, s != 0);
        end
        if (s == 2)
          chk(scr_din == {PAT[2*(i%8)], PAT[2*(i%8)+1]}, "R5 bridge din", scr_din,
              {PAT[2*(i%8)], PAT[2*(i%8)+1]});
        else if (s != 0)
          chk(scr_din == 2'b11, "R12 ones din", scr_din, 3);
        if (s == 3 && i == 0) begin
          chk(enc_init, "R7 enc_init", enc_init, 1);
          chk(dif_seed == seed, "R7 dif_seed", dif_seed, seed);
        end
        if (s == 1 && i == drop_at) rts = 1'b0;
        step(d);
        case (s)
          0: begin
            chk(sym_kind == 2'b01 && sym_label == (i % 2 ? 2'd1 : 2'd0),
                "R2 alternation", sym_label, i % 2);
            prev = sym_label;
          end
          1: begin
            chk(sym_kind == 2'b01 && sym_label == EQ_TAB[d],
                is_long ? "R4 eq map" : "R3 resync eq", sym_label, EQ_TAB[d]);
            if (!is_long && i == len - 1) seed = EQ_TAB[d];
            prev = EQ_TAB[d];
          end
          2: begin
            chk(sym_kind == 2'b01 && sym_label == 2'(prev + ROT_TAB[d]),
                "R6 bridge rotation", sym_label, 2'(prev + ROT_TAB[d]));
            prev = 2'(prev + ROT_TAB[d]);
            if (i == 0) seed = prev;
          end
          default: begin
            chk(sym_kind == 2'b10, is_long ? "R2 data-mode training" : "R3 data-mode training",
                sym_kind, 2);
            if (i < len - 1) chk(!cts, "R8 cts early", cts, 0);
          end
        endcase
      end
    end
  endtask

  task automatic turn_off(input int raise_at);
    for (int i = 0; i < 32; i++) begin
      chk(scr_run && scr_din == 2'b11, "R12 tail scrambler", scr_din, 3);
      if (i == raise_at) rts = 1'b1;
      step(next_dibit());
      chk(sym_kind == 2'b10 && !cts, "R9 tail data-mode", sym_kind, 2);
    end
    for (int i = 0; i < 48; i++) begin
      step(next_dibit());
      chk(sym_kind == 2'b00, "R10 tail silent despite rts", sym_kind, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sym_kind == 2'b00, "R1 reset kind", sym_kind, 0);
    chk(!cts, "R1 reset cts", cts, 0);
    chk(!scr_run, "R1 reset scr_run", scr_run, 0);

    rts = 1'b1;
    run_train(1'b1, -1);
    chk(cts, "R8 cts after training", cts, 1);
    chk(scr_use_data, "R8 data routed", scr_use_data, 1);
    for (int i = 0; i < 3; i++) begin
      step(next_dibit());
      chk(cts && sym_kind == 2'b10, "R8 data mode holds", cts, 1);
    end
    rts = 1'b0;
    step(next_dibit());
    chk(!cts, "R9 cts drop", cts, 0);
    chk(!scr_use_data, "R9 data unrouted", scr_use_data, 0);
    turn_off(10);

    // rts raised in the tail; next train is a resync with rts dropped mid-equalizer
    run_train(1'b0, 100);
    chk(!cts, "R11 no cts after dropped rts", cts, 0);
    turn_off(-1);
    step(2'b00);
    chk(sym_kind == 2'b00 && !cts, "R11 idle after tail", sym_kind, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule